// File: doc/BRIEF.md
# Partial-Width Overlapping Register File

This block is a general-purpose register file of sixteen 64-bit registers. Each register can be reached through several narrower windows as well as its full width: the low 32 bits, the low 16 bits, the lowest byte and the byte just above it. Every window is a part of the same 64-bit storage. There is no separate register behind a window.

One write port and two independent combinational read ports each choose a register index and a window. A write changes the bits outside its window in a way that depends on the window. A 32-bit write clears the upper half. Writes of 16 bits and of a single byte leave every bit outside the window as it was. Reads return the chosen window shifted down to bit 0, with zeros above it.

The block is meant for an execution datapath that must keep narrow operations compatible with older code while holding full-width state.

Top module: `gpr_view_file`

## Requirements
- R1: There are 16 registers of 64 bits. A write with window code 0 (full) stores all of `wr_data`, and a full-window read returns all 64 bits.
- R2: A write with window code 1 (32-bit) stores `wr_data[31:0]` into bits 31:0 and forces bits 63:32 to zero.
- R3: A write with window code 2 (16-bit) stores `wr_data[15:0]` into bits 15:0 and leaves bits 63:16 unchanged.
- R4: A write with window code 3 (low byte) stores `wr_data[7:0]` into bits 7:0 and leaves bits 63:8 unchanged.
- R5: A write with window code 4 (high byte) stores `wr_data[7:0]` into bits 15:8 and leaves bits 63:16 and 7:0 unchanged.
- R6: A write with a window code of 5, 6 or 7 changes no register.
- R7: Each read port returns its window right-aligned and zero-extended to 64 bits. A high-byte read (code 4) returns bits 15:8 in output bits 7:0. Window codes 5 to 7 read as zero.
- R8: The two read ports are independent. Each port returns its own register and window in the same cycle.
- R9: A read of the register being written returns the old contents in the cycle of the write. The new value is visible from the next cycle.
- R10: A synchronous active-high `rst` clears all registers to zero. When `wr_en` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register index written |
| wr_view | input | 3 | Window code of the write |
| wr_data | input | 64 | Write data, right-aligned for narrow windows |
| ra_idx | input | 4 | Read port A register index |
| ra_view | input | 3 | Read port A window code |
| ra_data | output | 64 | Read port A result, zero-extended |
| rb_idx | input | 4 | Read port B register index |
| rb_view | input | 3 | Read port B window code |
| rb_data | output | 64 | Read port B result, zero-extended |

## Verification
The bench first walks a chain of mixed-width writes to one register, so each step depends on what the earlier steps left behind. A 32-bit write that merged instead of clearing shows up as stale upper bits. A 16-bit or byte write that cleared instead of merging loses the neighbouring bytes. A high-byte write that picked the wrong source byte or the wrong target byte shows up as a misplaced value. The bench also checks that unused window codes neither write nor read, and that a read in the cycle of a write returns the old value and not forwarded data. A long random run of mixed writes, with both read ports on random windows, catches index or port cross-talk.

// File: rtl/gprv_pkg.sv
package gprv_pkg;

    // Window codes shared by the write merge and the read extract
    typedef enum logic [2:0] {
        VW_FULL = 3'd0,
        VW_W32  = 3'd1,
        VW_W16  = 3'd2,
        VW_BLO  = 3'd3,
        VW_BHI  = 3'd4
    } view_e;

endpackage

// File: rtl/gprv_wr_merge.sv
module gprv_wr_merge
    import gprv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [2:0]      view,
    input  logic [XLEN-1:0] data,
    output logic [XLEN-1:0] new_val,
    output logic            valid
);

    // Builds the next register value from the old one and the write window
    always_comb begin
        new_val = old_val;
        valid   = 1'b1;
        case (view_e'(view))
            VW_FULL: new_val = data;
            VW_W32: begin
                new_val       = '0;
                new_val[31:0] = data[31:0];
            end
            VW_W16:  new_val[15:0] = data[15:0];
            VW_BLO:  new_val[7:0]  = data[7:0];
            VW_BHI:  new_val[15:8] = data[7:0];
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/gprv_rd_extract.sv
module gprv_rd_extract
    import gprv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    input  logic [2:0]      view,
    output logic [XLEN-1:0] out
);

    // Right-aligns the chosen window and zero-extends it
    always_comb begin
        out = '0;
        case (view_e'(view))
            VW_FULL: out       = val;
            VW_W32:  out[31:0] = val[31:0];
            VW_W16:  out[15:0] = val[15:0];
            VW_BLO:  out[7:0]  = val[7:0];
            VW_BHI:  out[7:0]  = val[15:8];
            default: out       = '0;
        endcase
    end

endmodule

// File: rtl/gpr_view_file.sv
module gpr_view_file
    import gprv_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int XLEN     = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_view,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [2:0]       ra_view,
    output logic [XLEN-1:0]  ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic [2:0]       rb_view,
    output logic [XLEN-1:0]  rb_data
);

    logic [XLEN-1:0] regs_q [NUM_REGS];
    logic [XLEN-1:0] merged;
    logic            merge_ok;

    gprv_wr_merge #(.XLEN(XLEN)) merge_i (
        .old_val (regs_q[wr_idx]),
        .view    (wr_view),
        .data    (wr_data),
        .new_val (merged),
        .valid   (merge_ok)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr_en && merge_ok && (wr_idx == IDX_W'(i))) begin
                regs_q[i] <= merged;
            end
        end

        // R10: reset clears the register
        a_r10_reset_clear: assert property (@(posedge clk)
            rst |=> regs_q[i] == '0);
        // R10: no write to this register leaves it unchanged
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(regs_q[i]));
        // R2: 32-bit write clears the upper half
        a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(i) && wr_view == 3'd1)
            |=> regs_q[i][XLEN-1:32] == '0);
        // R3: 16-bit write keeps bits above 15
        a_r3_keep_upper: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(i) && wr_view == 3'd2)
            |=> $stable(regs_q[i][XLEN-1:16]));
        // R4: low-byte write keeps bits above 7
        a_r4_keep_upper: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(i) && wr_view == 3'd3)
            |=> $stable(regs_q[i][XLEN-1:8]));
        // R5: high-byte write lands in bits 15:8 and keeps the rest
        a_r5_hi_byte: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(i) && wr_view == 3'd4)
            |=> $stable(regs_q[i][7:0]) && $stable(regs_q[i][XLEN-1:16])
                && regs_q[i][15:8] == $past(wr_data[7:0]));
        // R6: unused window codes write nothing
        a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_view > 3'd4) |=> $stable(regs_q[i]));
    end

    gprv_rd_extract #(.XLEN(XLEN)) rd_a_i (
        .val  (regs_q[ra_idx]),
        .view (ra_view),
        .out  (ra_data)
    );

    gprv_rd_extract #(.XLEN(XLEN)) rd_b_i (
        .val  (regs_q[rb_idx]),
        .view (rb_view),
        .out  (rb_data)
    );

    // R7: high-byte and byte reads are zero above bit 7
    a_r7_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (ra_view == 3'd3 || ra_view == 3'd4) |-> ra_data[XLEN-1:8] == '0);
    // R7: 16-bit reads on port B are zero above bit 15
    a_r7_half_zext: assert property (@(posedge clk) disable iff (rst)
        (rb_view == 3'd2) |-> rb_data[XLEN-1:16] == '0);

endmodule

// File: tb/gpr_view_file_tb_top.sv
module gpr_view_file_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [2:0]  wr_view = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  ra_idx = '0;
    logic [2:0]  ra_view = '0;
    logic [63:0] ra_data;
    logic [3:0]  rb_idx = '0;
    logic [2:0]  rb_view = '0;
    logic [63:0] rb_data;

    int total = 0;
    int bad   = 0;
    logic [63:0] mdl [16];

    always #10 clk = ~clk;   // 50 MHz

    gpr_view_file dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_view(wr_view), .wr_data(wr_data),
        .ra_idx(ra_idx), .ra_view(ra_view), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_view(rb_view), .rb_data(rb_data)
    );

    // entry: {idx[3:0], view[2:0], data[63:0], expected full value[63:0]}
    // The entries chain on the same register, each applied after the one before.
    localparam logic [134:0] TBL [10] = '{
        {4'd3,  3'd0, 64'h1122334455667788, 64'h1122334455667788}, // R1
        {4'd3,  3'd2, 64'hFFFFFFFFFFFFAAAA, 64'h112233445566AAAA}, // R3
        {4'd3,  3'd3, 64'hFFFFFFFFFFFFFF5B, 64'h112233445566AA5B}, // R4
        {4'd3,  3'd4, 64'hFFFFFFFFFFFFFFC3, 64'h112233445566C35B}, // R5
        {4'd3,  3'd1, 64'hDEADBEEF0BADF00D, 64'h000000000BADF00D}, // R2
        {4'd3,  3'd5, 64'hFFFFFFFFFFFFFFFF, 64'h000000000BADF00D}, // R6
        {4'd3,  3'd7, 64'hFFFFFFFFFFFFFFFF, 64'h000000000BADF00D}, // R6
        {4'd15, 3'd0, 64'hCAFEBABE12345678, 64'hCAFEBABE12345678}, // R1
        {4'd15, 3'd4, 64'h5555555555555500, 64'hCAFEBABE12340078}, // R5
        {4'd0,  3'd3, 64'h00000000000000EE, 64'h00000000000000EE}  // R4
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mdl_write(logic [63:0] old, logic [2:0] v, logic [63:0] d);
        logic [63:0] r = old;
        case (v)
            3'd0: r = d;
            3'd1: r = {32'h0, d[31:0]};
            3'd2: r[15:0] = d[15:0];
            3'd3: r[7:0] = d[7:0];
            3'd4: r[15:8] = d[7:0];
            default: r = old;
        endcase
        return r;
    endfunction

    function automatic logic [63:0] mdl_read(logic [63:0] val, logic [2:0] v);
        case (v)
            3'd0: return val;
            3'd1: return {32'h0, val[31:0]};
            3'd2: return {48'h0, val[15:0]};
            3'd3: return {56'h0, val[7:0]};
            3'd4: return {56'h0, val[15:8]};
            default: return 64'h0;
        endcase
    endfunction

    task automatic do_write(input logic [3:0] i, input logic [2:0] v, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_view = v; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: every register reads zero after reset
        for (int k = 0; k < 16; k++) begin
            ra_idx = 4'(k); ra_view = 3'd0; #1;
            chk("R10 reset", ra_data, 64'h0);
        end

        // Table walk; port B reads the 16-bit window of the same register
        for (int n = 0; n < 10; n++) begin
            do_write(TBL[n][134:131], TBL[n][130:128], TBL[n][127:64]);
            ra_idx = TBL[n][134:131]; ra_view = 3'd0;
            rb_idx = TBL[n][134:131]; rb_view = 3'd2; #1;
            chk("R1-R6 table full", ra_data, TBL[n][63:0]);
            chk("R8 table port B", rb_data, {48'h0, TBL[n][15:0]});
        end

        // R7: each read window of register 15 (CAFEBABE12340078)
        ra_idx = 4'd15; rb_idx = 4'd15;
        ra_view = 3'd4; rb_view = 3'd3; #1;
        chk("R7 high byte read", ra_data, 64'h00);
        chk("R7 low byte read", rb_data, 64'h78);
        ra_view = 3'd1; rb_view = 3'd6; #1;
        chk("R7 32-bit read", ra_data, 64'h12340078);
        chk("R7 bad code read", rb_data, 64'h0);
        // R8: different registers on the two ports
        ra_idx = 4'd3; ra_view = 3'd0; rb_idx = 4'd0; rb_view = 3'd0; #1;
        chk("R8 port A", ra_data, 64'h000000000BADF00D);
        chk("R8 port B", rb_data, 64'h00000000000000EE);

        // R9: read of the register being written shows the old value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd3; wr_view = 3'd0; wr_data = 64'hA5A5A5A5A5A5A5A5;
        ra_idx = 4'd3; ra_view = 3'd0; #1;
        chk("R9 old value", ra_data, 64'h000000000BADF00D);
        @(negedge clk);
        wr_en = 1'b0; #1;
        chk("R9 new value", ra_data, 64'hA5A5A5A5A5A5A5A5);

        // R10: data presented with wr_en low is ignored
        @(negedge clk);
        wr_idx = 4'd3; wr_view = 3'd0; wr_data = 64'h0;
        @(negedge clk); #1;
        chk("R10 enable low", ra_data, 64'hA5A5A5A5A5A5A5A5);

        // R10: reset in mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R10 mid reset", ra_data, 64'h0);
        rb_idx = 4'd15; rb_view = 3'd0; #1;
        chk("R10 mid reset reg15", rb_data, 64'h0);

        // R8: random mixed writes against a reference array
        for (int k = 0; k < 16; k++) mdl[k] = 64'h0;
        for (int c = 0; c < 400; c++) begin
            logic [3:0]  wi;
            logic [2:0]  wv;
            logic [63:0] wd;
            logic        we;
            @(negedge clk);
            wi = 4'($urandom); wv = 3'($urandom); wd = {$urandom, $urandom};
            we = 1'($urandom);
            wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
            ra_idx = 4'($urandom); ra_view = 3'($urandom);
            rb_idx = 4'($urandom); rb_view = 3'($urandom);
            #1;
            chk("R8 random port A", ra_data, mdl_read(mdl[ra_idx], ra_view));
            chk("R8 random port B", rb_data, mdl_read(mdl[rb_idx], rb_view));
            if (we) mdl[wi] = mdl_write(mdl[wi], wv, wd);
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < 16; k++) begin
            ra_idx = 4'(k); ra_view = 3'd0; #1;
            chk("R8 random final", ra_data, mdl[k]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule